// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Sequencer

This block drives the serial programming port of a dual-modulus PLL frequency synthesizer as the master. A start command carries a target RF frequency in MHz; the block splits it into the B and A counts for a fixed prescaler of 32 with a 1 MHz comparison frequency. It then sends three 24-bit words over a clock, data and latch-enable wire set. A separate set command changes one settings field at a time, such as charge-pump current, timeout count, mux output, lock-detect precision or anti-backlash width. These changes are only stored. They reach the wire with the next start.

Every wire phase lasts a whole number of system-clock cycles, set by parameters. With the default values and a 100 MHz system clock, the serial clock is high for 30 ns and low for 30 ns. Data is set up 30 ns before each rising edge and held 30 ns after it. The latch pulse lasts 20 ns, and a 20 ns gap follows it before the next word. The first successful start after reset marks its settings word as an initialization word. Later starts mark it as a plain function word.

Top module: `synth_prog_seq`

## Requirements
- R1: Each word is 24 bits, shifted most significant bit first, one bit per rising edge of `syn_clk_o`. `syn_data_o` changes only when `syn_clk_o` falls or while it is low, and it is stable for at least HALF_CYC cycles before each rising edge.
- R2: `syn_clk_o` is high for exactly HALF_CYC cycles per bit. `syn_le_o` stays low while bits shift. After the 24th rising edge, with the clock low, `syn_le_o` goes high for exactly LE_CYC cycles. At least GAP_CYC cycles then pass before the next rising clock edge.
- R3: An accepted start sends exactly three words in this order: settings word, reference word, counter word.
- R4: Bits 1:0 of each word select its destination: 00 reference, 01 counter, 10 function, 11 initialization. The first accepted start after reset sends 11 on the settings word. Every later accepted start sends 10, with identical upper bits.
- R5: The counter word has B = f/32 in bits 20:8 and A = f mod 32 in bits 7:2. All other upper bits are zero.
- R6: The reference word has the divider 10 in bits 15:2, lock-detect precision in bit 20 and anti-backlash width in bits 17:16. All other upper bits are zero.
- R7: The settings word has bit 23 = 1 and bit 7 = 1. It holds the pump current in both bits 20:18 and 17:15, the timeout in bits 14:11 and the mux in bits 6:4. All other bits are zero. After reset the mux is 4 and the other fields are 0, so the words are 0x8000C3 and 0x000028.
- R8: A set command writes `set_val_i` into one field, chosen by `set_sel_i`: 0 lock precision (bit 0), 1 anti-backlash (bits 1:0), 2 pump current (bits 2:0), 3 timeout (bits 3:0), 4 mux (bits 2:0). Codes 5 to 7 change nothing. Repeated writes keep the last value. Nothing reaches the wire until the next start.
- R9: `busy_o` is high from the cycle after an accepted start until the gap after the third latch pulse ends. A start or set command that arrives while busy, or a set that arrives in the same cycle as a start, is ignored. One cycle later `cmd_drop_o` pulses.
- R10: A start whose B count is smaller than its A count is rejected. `freq_err_o` pulses one cycle later, no wire activity follows, and the pending initialization marking stays pending. B equal to A is accepted.
- R11: During reset and after it, `syn_clk_o`, `syn_data_o`, `syn_le_o`, `busy_o`, `cmd_drop_o` and `freq_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start command, one cycle |
| freq_i | input | FREQ_W | Target frequency in MHz, sampled with start_i |
| set_i | input | 1 | Set-field command, one cycle |
| set_sel_i | input | 3 | Field selector for the set command |
| set_val_i | input | 4 | Field value for the set command |
| syn_clk_o | output | 1 | Serial clock to the synthesizer |
| syn_data_o | output | 1 | Serial data to the synthesizer |
| syn_le_o | output | 1 | Latch enable to the synthesizer |
| busy_o | output | 1 | Transfer in progress |
| cmd_drop_o | output | 1 | Pulse: a command was ignored |
| freq_err_o | output | 1 | Pulse: start rejected because B < A |

## Verification
The assertions assume that `start_i` and `set_i` are single-cycle pulses sampled on the system clock. They also assume the shifter is only loaded by the sequencer while it is idle. The remaining properties concern command dropping, settings stability while busy, and the clock high time, which hold for any input values. The stimulus drives every command on the falling edge for exactly one cycle. Random set commands are only issued while the block is idle, except in one directed case that issues commands on purpose during a transfer. Random frequencies cover the whole 16-bit range, with a denser sweep below 1100 MHz where B < A rejections occur.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  localparam int WORD_W     = 24;
  localparam int RDIV_W     = 14;
  localparam int BCNT_W     = 13;
  localparam int ACNT_W     = 6;
  localparam int PRESC_LOG2 = 5;
  localparam int SEL_W      = 3;
  localparam int VAL_W      = 4;

  // destination codes in bits 1:0 of every word
  localparam logic [1:0] CTL_REF  = 2'b00;
  localparam logic [1:0] CTL_CNT  = 2'b01;
  localparam logic [1:0] CTL_FUNC = 2'b10;
  localparam logic [1:0] CTL_INIT = 2'b11;

  localparam logic [SEL_W-1:0] SEL_LOCK     = 3'd0;
  localparam logic [SEL_W-1:0] SEL_BACKLASH = 3'd1;
  localparam logic [SEL_W-1:0] SEL_PUMP     = 3'd2;
  localparam logic [SEL_W-1:0] SEL_TIMEOUT  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_MUX      = 3'd4;

  typedef struct packed {
    logic       lock_prec;
    logic [1:0] backlash;
    logic [2:0] pump;
    logic [3:0] timeout;
    logic [2:0] mux;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{lock_prec: 1'b0, backlash: 2'd0,
                                   pump: 3'd0, timeout: 4'd0, mux: 3'd4};

  function automatic cfg_t cfg_apply(cfg_t c, logic [SEL_W-1:0] sel,
                                     logic [VAL_W-1:0] val);
    cfg_t r;
    r = c;
    case (sel)
      SEL_LOCK:     r.lock_prec = val[0];
      SEL_BACKLASH: r.backlash  = val[1:0];
      SEL_PUMP:     r.pump      = val[2:0];
      SEL_TIMEOUT:  r.timeout   = val;
      SEL_MUX:      r.mux       = val[2:0];
      default:      r = c;
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] settings_word(cfg_t c, logic first);
    return {1'b1, 2'b00, c.pump, c.pump, c.timeout, 3'b000, 1'b1, c.mux,
            2'b00, (first ? CTL_INIT : CTL_FUNC)};
  endfunction

  function automatic logic [WORD_W-1:0] ref_word(cfg_t c, logic [RDIV_W-1:0] rdiv);
    return {3'b000, c.lock_prec, 2'b00, c.backlash, rdiv, CTL_REF};
  endfunction

  function automatic logic [WORD_W-1:0] cnt_word(logic [BCNT_W-1:0] b,
                                                 logic [ACNT_W-1:0] a);
    return {3'b000, b, a, CTL_CNT};
  endfunction

endpackage

// File: rtl/synth_freq_split.sv
module synth_freq_split
  import synth_prog_pkg::*;
#(
  parameter int FREQ_W = 16
) (
  input  logic [FREQ_W-1:0] freq_i,
  output logic [BCNT_W-1:0] b_cnt_o,
  output logic [ACNT_W-1:0] a_cnt_o,
  output logic              ok_o
);

  localparam int QUOT_W = FREQ_W - PRESC_LOG2;

  logic [QUOT_W-1:0]     quot;
  logic [PRESC_LOG2-1:0] rem;

  // divide by the fixed prescaler modulus: a shift and a mask
  assign quot    = freq_i[FREQ_W-1:PRESC_LOG2];
  assign rem     = freq_i[PRESC_LOG2-1:0];
  assign b_cnt_o = BCNT_W'(quot);
  assign a_cnt_o = ACNT_W'(rem);
  // the dual-modulus split needs B >= A
  assign ok_o    = (quot >= QUOT_W'(rem));

endmodule

// File: rtl/synth_word_shifter.sv
module synth_word_shifter
  import synth_prog_pkg::*;
#(
  parameter int HALF_CYC = 3,
  parameter int LE_CYC   = 2,
  parameter int GAP_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sle_o,
  output logic              done_o
);

  localparam int MAX_AB = (HALF_CYC > LE_CYC) ? HALF_CYC : LE_CYC;
  localparam int MAX_C  = (MAX_AB > GAP_CYC) ? MAX_AB : GAP_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam int IDX_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] LE_M1   = CNT_W'(LE_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_M1  = CNT_W'(GAP_CYC - 1);

  typedef enum logic [2:0] {SH_IDLE, SH_LOW, SH_HIGH, SH_LATCH, SH_GAP} sh_e;

  sh_e               st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              sclk_q, sclk_d;
  logic              sdat_q, sdat_d;
  logic              sle_q, sle_d;
  logic              done_q, done_d;
  logic [IDX_W-1:0]  idx_dec;

  assign idx_dec = idx_q - IDX_W'(1);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    word_d = word_q;
    sclk_d = sclk_q;
    sdat_d = sdat_q;
    sle_d  = sle_q;
    done_d = 1'b0;
    case (st_q)
      SH_IDLE: begin
        if (load_i) begin
          word_d = word_i;
          idx_d  = IDX_W'(WORD_W - 1);
          sdat_d = word_i[WORD_W-1];
          sclk_d = 1'b0;
          cnt_d  = HALF_M1;
          st_d   = SH_LOW;
        end
      end
      SH_LOW: begin
        if (cnt_q == '0) begin
          sclk_d = 1'b1;
          cnt_d  = HALF_M1;
          st_d   = SH_HIGH;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SH_HIGH: begin
        if (cnt_q == '0) begin
          sclk_d = 1'b0;
          if (idx_q == '0) begin
            sle_d = 1'b1;
            cnt_d = LE_M1;
            st_d  = SH_LATCH;
          end else begin
            idx_d  = idx_dec;
            sdat_d = word_q[idx_dec];
            cnt_d  = HALF_M1;
            st_d   = SH_LOW;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SH_LATCH: begin
        if (cnt_q == '0) begin
          sle_d = 1'b0;
          cnt_d = GAP_M1;
          st_d  = SH_GAP;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SH_GAP: begin
        if (cnt_q == '0) begin
          sdat_d = 1'b0;
          done_d = 1'b1;
          st_d   = SH_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      word_q <= '0;
      sclk_q <= 1'b0;
      sdat_q <= 1'b0;
      sle_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      word_q <= word_d;
      sclk_q <= sclk_d;
      sdat_q <= sdat_d;
      sle_q  <= sle_d;
      done_q <= done_d;
    end
  end

  assign sclk_o  = sclk_q;
  assign sdata_o = sdat_q;
  assign sle_o   = sle_q;
  assign done_o  = done_q;

  // independent run-length counter for the clock high phase
  logic [CNT_W:0] chk_hi_q;
  localparam logic [CNT_W:0] HALF_L = (CNT_W + 1)'(HALF_CYC);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chk_hi_q <= '0;
    else if (sclk_q) chk_hi_q <= chk_hi_q + (CNT_W + 1)'(1);
    else chk_hi_q <= '0;
  end

  a_r2_le_clk_exclusive: assert property (@(posedge clk) disable iff (!rst_ni)
    sle_q |-> !sclk_q);
  a_r2_clk_high_width: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(sclk_q) |-> (chk_hi_q == HALF_L));
  a_r1_data_held_high: assert property (@(posedge clk) disable iff (!rst_ni)
    (sclk_q && $past(sclk_q)) |-> $stable(sdat_q));
  a_r3_load_when_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |-> (st_q == SH_IDLE));

endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
  import synth_prog_pkg::*;
#(
  parameter int FREQ_W   = 16,
  parameter int HALF_CYC = 3,
  parameter int LE_CYC   = 2,
  parameter int GAP_CYC  = 2,
  parameter int R_DIV    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic              set_i,
  input  logic [SEL_W-1:0]  set_sel_i,
  input  logic [VAL_W-1:0]  set_val_i,
  output logic              syn_clk_o,
  output logic              syn_data_o,
  output logic              syn_le_o,
  output logic              busy_o,
  output logic              cmd_drop_o,
  output logic              freq_err_o
);

  localparam logic [RDIV_W-1:0] RDIV_VAL = RDIV_W'(R_DIV);
  localparam logic [1:0]        LAST_IDX = 2'd2;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  typedef enum logic {SQ_IDLE, SQ_RUN} sq_e;

  sq_e               st_q, st_d;
  logic [1:0]        widx_q, widx_d;
  logic              kick_q, kick_d;
  cfg_t              cfg_q, cfg_d;
  logic              init_pend_q, init_pend_d;
  logic              use_init_q, use_init_d;
  logic [BCNT_W-1:0] b_q, b_d;
  logic [ACNT_W-1:0] a_q, a_d;
  logic              drop_q, drop_d;
  logic              ferr_q, ferr_d;

  logic [BCNT_W-1:0] b_calc;
  logic [ACNT_W-1:0] a_calc;
  logic              split_ok;
  logic              sh_done;
  logic [WORD_W-1:0] tx_word;

  synth_freq_split #(.FREQ_W(FREQ_W)) u_split (
    .freq_i  (freq_i),
    .b_cnt_o (b_calc),
    .a_cnt_o (a_calc),
    .ok_o    (split_ok)
  );

  always_comb begin
    case (widx_q)
      2'd0:    tx_word = settings_word(cfg_q, use_init_q);
      2'd1:    tx_word = ref_word(cfg_q, RDIV_VAL);
      default: tx_word = cnt_word(b_q, a_q);
    endcase
  end

  synth_word_shifter #(
    .HALF_CYC (HALF_CYC),
    .LE_CYC   (LE_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_shift (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .load_i  (kick_q),
    .word_i  (tx_word),
    .sclk_o  (syn_clk_o),
    .sdata_o (syn_data_o),
    .sle_o   (syn_le_o),
    .done_o  (sh_done)
  );

  always_comb begin
    st_d        = st_q;
    widx_d      = widx_q;
    kick_d      = 1'b0;
    cfg_d       = cfg_q;
    init_pend_d = init_pend_q;
    use_init_d  = use_init_q;
    b_d         = b_q;
    a_d         = a_q;
    drop_d      = 1'b0;
    ferr_d      = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          drop_d = set_i;
          if (split_ok) begin
            st_d        = SQ_RUN;
            widx_d      = 2'd0;
            kick_d      = 1'b1;
            b_d         = b_calc;
            a_d         = a_calc;
            use_init_d  = init_pend_q;
            init_pend_d = 1'b0;
          end else begin
            ferr_d = 1'b1;
          end
        end else if (set_i) begin
          cfg_d = cfg_apply(cfg_q, set_sel_i, set_val_i);
        end
      end
      SQ_RUN: begin
        drop_d = start_i | set_i;
        if (sh_done) begin
          if (widx_q == LAST_IDX) begin
            st_d = SQ_IDLE;
          end else begin
            widx_d = widx_q + 2'd1;
            kick_d = 1'b1;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SQ_IDLE;
      widx_q      <= 2'd0;
      kick_q      <= 1'b0;
      cfg_q       <= CFG_DEFAULT;
      init_pend_q <= 1'b1;
      use_init_q  <= 1'b0;
      b_q         <= '0;
      a_q         <= '0;
      drop_q      <= 1'b0;
      ferr_q      <= 1'b0;
    end else begin
      st_q        <= st_d;
      widx_q      <= widx_d;
      kick_q      <= kick_d;
      cfg_q       <= cfg_d;
      init_pend_q <= init_pend_d;
      use_init_q  <= use_init_d;
      b_q         <= b_d;
      a_q         <= a_d;
      drop_q      <= drop_d;
      ferr_q      <= ferr_d;
    end
  end

  assign busy_o     = (st_q == SQ_RUN);
  assign cmd_drop_o = drop_q;
  assign freq_err_o = ferr_q;

  a_r9_drop_when_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_o && (start_i || set_i)) |=> cmd_drop_o);
  a_r8_cfg_frozen_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_o |=> $stable(cfg_q));
  a_r10_reject_no_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy_o && start_i && !split_ok) |=> (freq_err_o && !busy_o));
  a_r4_init_once: assert property (@(posedge clk) disable iff (!rst_ni)
    !init_pend_q |=> !init_pend_q);
  a_r3_word_index: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_o |-> (widx_q <= LAST_IDX));
  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy_o && !kick_q) |-> (!syn_clk_o && !syn_le_o));

endmodule

// File: tb/test_synth_prog_seq.sv
module test_synth_prog_seq;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int LEC  = 2;
  localparam int GAPC = 2;

  logic        clk, rst_n, start_i, set_i;
  logic [15:0] freq_i;
  logic [2:0]  set_sel_i;
  logic [3:0]  set_val_i;
  logic        syn_clk_o, syn_data_o, syn_le_o, busy_o, cmd_drop_o, freq_err_o;

  synth_prog_seq #(.FREQ_W(16), .HALF_CYC(HALF), .LE_CYC(LEC), .GAP_CYC(GAPC), .R_DIV(10))
  i_synth_prog_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .freq_i(freq_i),
    .set_i(set_i), .set_sel_i(set_sel_i), .set_val_i(set_val_i),
    .syn_clk_o(syn_clk_o), .syn_data_o(syn_data_o), .syn_le_o(syn_le_o),
    .busy_o(busy_o), .cmd_drop_o(cmd_drop_o), .freq_err_o(freq_err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model of the stored settings
  logic       m_lock;
  logic [1:0] m_bl;
  logic [2:0] m_pump;
  logic [3:0] m_tout;
  logic [2:0] m_mux;
  bit         m_first;

  function automatic logic [23:0] e_set(bit first);
    return {1'b1, 2'b00, m_pump, m_pump, m_tout, 3'b000, 1'b1, m_mux, 2'b00,
            (first ? 2'b11 : 2'b10)};
  endfunction
  function automatic logic [23:0] e_ref();
    return {3'b000, m_lock, 2'b00, m_bl, 14'd10, 2'b00};
  endfunction
  function automatic logic [23:0] e_cnt(int f);
    return {3'b000, 13'(f / 32), 6'(f % 32), 2'b01};
  endfunction

  // wire monitor
  logic [23:0] cap [0:255];
  int   ncap = 0;
  logic [23:0] sh;
  int   bits, hi_run, stab, le_run, since_le;
  bit   tbad;
  logic pclk, ple, pdat;

  always @(negedge clk) begin
    if (!rst_n) begin
      bits = 0; hi_run = 0; stab = 0; le_run = 0; since_le = 1000; tbad = 0;
      pclk = 0; ple = 0; pdat = 0; sh = '0;
    end else begin
      if (syn_clk_o && !pclk) begin
        if (stab < HALF || syn_le_o || since_le < GAPC) tbad = 1;
        sh = {sh[22:0], syn_data_o};
        bits++;
        hi_run = 1;
      end else if (syn_clk_o) begin
        hi_run++;
        if (syn_data_o !== pdat) tbad = 1;
      end
      if (!syn_clk_o && pclk && hi_run != HALF) tbad = 1;
      stab = (syn_data_o === pdat) ? stab + 1 : 1;
      since_le++;
      if (syn_le_o && !ple) begin
        if (bits != 24 || syn_clk_o) tbad = 1;
        le_run = 1;
        if (ncap < 256) cap[ncap] = sh;
      end else if (syn_le_o) begin
        le_run++;
      end
      if (!syn_le_o && ple) begin
        if (le_run != LEC) tbad = 1;
        n_cmp++;
        if (tbad) begin
          n_bad++;
          $display("FAIL R1/R2 word timing actual=1 expected=0");
        end
        tbad = 0; bits = 0; since_le = 0;
        ncap++;
      end
      pclk = syn_clk_o; ple = syn_le_o; pdat = syn_data_o;
    end
  end

  task automatic do_set(logic [2:0] sel, logic [3:0] val);
    @(negedge clk);
    set_i = 1'b1; set_sel_i = sel; set_val_i = val;
    @(negedge clk);
    set_i = 1'b0;
    case (sel)
      3'd0: m_lock = val[0];
      3'd1: m_bl   = val[1:0];
      3'd2: m_pump = val[2:0];
      3'd3: m_tout = val;
      3'd4: m_mux  = val[2:0];
      default: ;
    endcase
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic do_start(int f);
    int base;
    bit ok;
    wait_idle();
    base = ncap;
    @(negedge clk);
    start_i = 1'b1; freq_i = 16'(f);
    @(negedge clk);
    start_i = 1'b0;
    ok = (f / 32) >= (f % 32);
    if (!ok) begin
      chk("R10 reject flag", {30'd0, freq_err_o, busy_o}, 32'h2);
      repeat (40) @(negedge clk);
      chk("R10 no wire activity", ncap - base, 0);
    end else begin
      chk("R9 busy after start", {31'd0, busy_o}, 1);
      wait_idle();
      chk("R3 three words", ncap - base, 3);
      chk("R4 R7 settings word", cap[base], e_set(m_first));
      chk("R6 reference word", cap[base + 1], e_ref());
      chk("R5 counter word", cap[base + 2], e_cnt(f));
      m_first = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd4113));
    rst_n = 1'b0; start_i = 1'b0; set_i = 1'b0; freq_i = '0;
    set_sel_i = '0; set_val_i = '0;
    m_lock = 0; m_bl = 0; m_pump = 0; m_tout = 0; m_mux = 3'd4; m_first = 1;
    repeat (4) @(negedge clk);
    chk("R11 outputs in reset", {26'd0, syn_clk_o, syn_data_o, syn_le_o, busy_o,
        cmd_drop_o, freq_err_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 outputs after reset", {26'd0, syn_clk_o, syn_data_o, syn_le_o, busy_o,
        cmd_drop_o, freq_err_o}, 0);

    // R10: rejected start keeps the initialization marking pending
    do_start(31);
    do_start(991);
    // first accepted start: initialization word
    do_start(2476);
    chk("R7 default settings word", cap[ncap - 3], 32'h8000C3);
    chk("R5 2476 counter word", cap[ncap - 1], 32'h004D31);

    // R8: buffered changes, last write wins, unused selectors ignored
    do_set(3'd4, 4'd5);
    do_set(3'd0, 4'd1);
    do_set(3'd1, 4'd1);
    do_set(3'd2, 4'd6);
    do_set(3'd3, 4'd10);
    do_set(3'd4, 4'd2);
    do_set(3'd6, 4'd15);
    repeat (30) @(negedge clk);
    chk("R8 no wire activity on set", ncap, 3);
    do_start(2423);
    chk("R8 settings word", cap[ncap - 3], 32'h9B50A2);
    chk("R8 reference word", cap[ncap - 2], 32'h110028);
    chk("R5 2423 counter word", cap[ncap - 1], 32'h004B5D);

    // R9: commands during a transfer are dropped
    wait_idle();
    base = ncap;
    @(negedge clk); start_i = 1'b1; freq_i = 16'd2000;
    @(negedge clk); start_i = 1'b0; set_i = 1'b1; set_sel_i = 3'd4; set_val_i = 4'd7;
    @(negedge clk); set_i = 1'b0;
    chk("R9 drop set while busy", {31'd0, cmd_drop_o}, 1);
    start_i = 1'b1; freq_i = 16'd3000;
    @(negedge clk); start_i = 1'b0;
    chk("R9 drop start while busy", {31'd0, cmd_drop_o}, 1);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R9 only one transfer", ncap - base, 3);
    chk("R9 set ignored", cap[base], e_set(0));
    chk("R5 2000 counter word", cap[base + 2], e_cnt(2000));

    // R9: set in the same cycle as a start is dropped
    @(negedge clk); start_i = 1'b1; freq_i = 16'd1500;
    set_i = 1'b1; set_sel_i = 3'd3; set_val_i = 4'd3;
    @(negedge clk); start_i = 1'b0; set_i = 1'b0;
    chk("R9 drop set with start", {31'd0, cmd_drop_o}, 1);
    base = ncap;
    wait_idle();
    chk("R9 set with start ignored", cap[base], e_set(0));

    // boundaries of the A/B split
    do_start(1023);
    do_start(0);
    do_start(65535);
    do_start(32);

    // constrained random
    for (int it = 0; it < 30; it++) begin
      int nset;
      int f;
      nset = $urandom_range(0, 3);
      for (int k = 0; k < nset; k++)
        do_set(3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)));
      if ($urandom_range(0, 1) == 1) f = $urandom_range(0, 1100);
      else f = $urandom_range(0, 65535);
      do_start(f);
    end

    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule